// File: doc/BRIEF.md
# Access Control Attribute Matcher

This block decides the memory attributes of every reference that the processor puts on its local bus. It holds a small set of programmable region registers. Each region register names a value for the top address byte and a per-bit mask that turns chosen bits of that byte into don't-cares. It also carries an enable, a privilege qualifier, and three attributes: cache mode, buffered write and write protect. A request is compared against every enabled region. The lowest-numbered region that matches supplies the attributes. When no region matches, a separate default register supplies them.

The results appear one cycle after the request, qualified by a response valid. A write that lands in a write-protected region is stopped. The block pulses an access-error strobe and withholds the write-completion indication for that request. Reads of protected regions proceed as normal. Software programs the registers through a simple word-wide write and read port.

Top module: `acm_top`

## Requirements
- R1: After reset every region register and the default register read back as zero, so all regions are disabled. All response outputs are low.
- R2: Configuration address 0 selects region 0 and address 1 selects region 1. Address 2 selects the default register. Address 3 reads zero and ignores writes. In a region word, the base sits in [31:24], the mask in [23:16], the enable in bit 15, the mode in [14:13], cache mode in bit 6, buffered write in bit 5 and write protect in bit 2. The default word holds only bits 6, 5 and 2. All other bits read zero.
- R3: A region matches a request only when request address bits [31:24] equal its base in every bit position whose mask bit is 0. Positions whose mask bit is 1 are ignored.
- R4: A region whose enable bit is 0 never matches.
- R5: The mode field qualifies a match by privilege. 00 matches only user requests (reqSuper=0). 01 matches only supervisor requests. 10 and 11 match either.
- R6: When both regions match, region 0 supplies the attributes.
- R7: When no region matches, the attributes come from the default register.
- R8: One cycle after a request, rspValid equals the earlier reqValid. rspCacheable is the inverse of the selected cache-mode bit. rspBuffered is the selected buffered-write bit and rspWriteProt is the selected write-protect bit.
- R9: A valid write whose selected write-protect bit is 1 raises rspAccErr for exactly that response cycle, with rspWrDone low. A valid read under the same attributes raises no error.
- R10: A valid write whose selected write-protect bit is 0 raises rspWrDone. Reads and idle cycles raise neither rspWrDone nor rspAccErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read data for cfgAddr, combinational |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Request address |
| reqSuper | input | 1 | 1 = supervisor request, 0 = user request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspCacheable | output | 1 | Reference is cacheable |
| rspBuffered | output | 1 | Write may complete at once into the write buffer |
| rspWriteProt | output | 1 | Selected attributes are write protected |
| rspAccErr | output | 1 | Access-error strobe for a protected write |
| rspWrDone | output | 1 | Write completion for an allowed write |

## Verification
The bench aims requests at masked-compare boundaries: addresses that differ from a base only in masked bits, and addresses that differ in exactly one unmasked bit. A design that inverted the mask sense, or compared the wrong byte, would pick the wrong attributes there. It drives overlapping regions with conflicting attributes, where a wrong priority order shows up as swapped cache and protect flags. It also drives both privilege modes against every mode code, where a decode that treated 01 as "always" would let user traffic through. Protected reads and writes are mixed back to back. A design that raised errors on reads, or still signalled completion for a blocked write, would miscompare on the error and completion outputs.

// File: rtl/acm_pkg.sv
package acm_pkg;
  parameter int unsigned NUM_REGION = 2;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CFG_AW = $clog2(NUM_REGION + 2);
  localparam int unsigned DEF_SEL = NUM_REGION;

  localparam int unsigned BASE_LSB = 24;
  localparam int unsigned MASK_LSB = 16;
  localparam int unsigned EN_BIT = 15;
  localparam int unsigned MODE_LSB = 13;
  localparam int unsigned CM_BIT = 6;
  localparam int unsigned BW_BIT = 5;
  localparam int unsigned WP_BIT = 2;

  localparam logic [WORD_W-1:0] REGION_KEEP = 32'hFFFF_E064;
  localparam logic [WORD_W-1:0] DEF_KEEP = 32'h0000_0064;

  typedef struct packed {
    logic [NUM_REGION-1:0] regionWe;
    logic defWe;
    logic reqFire;
    logic reqWr;
  } acmStrobe_t;
endpackage

// File: rtl/acm_ctrl.sv
module acm_ctrl
  import acm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              reqValid,
  input  logic              reqWrite,
  output acmStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    for (int i = 0; i < int'(NUM_REGION); i++) begin
      strobe.regionWe[i] = cfgWe && (int'(cfgAddr) == i);
    end
    strobe.defWe = cfgWe && (int'(cfgAddr) == int'(DEF_SEL));
    strobe.reqFire = reqValid;
    strobe.reqWr = reqValid && reqWrite;
  end

  // R2
  cfg_we_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.regionWe, strobe.defWe}));
endmodule

// File: rtl/acm_dp.sv
module acm_dp
  import acm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  acmStrobe_t        strobe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgWdata,
  output logic [WORD_W-1:0] cfgRdata,
  input  logic [WORD_W-1:0] reqAddr,
  input  logic              reqSuper,
  output logic              rspValid,
  output logic              rspCacheable,
  output logic              rspBuffered,
  output logic              rspWriteProt,
  output logic              rspAccErr,
  output logic              rspWrDone
);
  logic [WORD_W-1:0] regionQ [NUM_REGION];
  logic [WORD_W-1:0] defQ;
  logic [NUM_REGION-1:0] hitVec;
  logic [NUM_REGION-1:0] selOh;
  logic [WORD_W-1:0] selWord;
  logic selWp;

  for (genvar g = 0; g < NUM_REGION; g++) begin : gRegion
    logic [7:0] baseF, maskF, diff;
    logic [1:0] modeF;
    logic modeOk;

    always_ff @(posedge clk) begin
      if (!rstN) regionQ[g] <= '0;
      else if (strobe.regionWe[g]) regionQ[g] <= cfgWdata & REGION_KEEP;
    end

    assign baseF = regionQ[g][BASE_LSB +: 8];
    assign maskF = regionQ[g][MASK_LSB +: 8];
    assign modeF = regionQ[g][MODE_LSB +: 2];
    assign diff = (baseF ^ reqAddr[BASE_LSB +: 8]) & ~maskF;
    assign modeOk = modeF[1] || (modeF[0] == reqSuper);
    assign hitVec[g] = regionQ[g][EN_BIT] && (diff == 8'd0) && modeOk;

    // R4
    dis_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
      !regionQ[g][EN_BIT] |-> !hitVec[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) defQ <= '0;
    else if (strobe.defWe) defQ <= cfgWdata & DEF_KEEP;
  end

  always_comb begin
    selOh = '0;
    selWord = defQ;
    for (int i = int'(NUM_REGION) - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selOh = '0;
        selOh[i] = 1'b1;
        selWord = regionQ[i];
      end
    end
  end

  assign selWp = selWord[WP_BIT];

  always_comb begin
    cfgRdata = '0;
    for (int i = 0; i < int'(NUM_REGION); i++) begin
      if (int'(cfgAddr) == i) cfgRdata = regionQ[i];
    end
    if (int'(cfgAddr) == int'(DEF_SEL)) cfgRdata = defQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCacheable <= 1'b0;
      rspBuffered <= 1'b0;
      rspWriteProt <= 1'b0;
      rspAccErr <= 1'b0;
      rspWrDone <= 1'b0;
    end else begin
      rspValid <= strobe.reqFire;
      rspCacheable <= strobe.reqFire && !selWord[CM_BIT];
      rspBuffered <= strobe.reqFire && selWord[BW_BIT];
      rspWriteProt <= strobe.reqFire && selWp;
      rspAccErr <= strobe.reqWr && selWp;
      rspWrDone <= strobe.reqWr && !selWp;
    end
  end

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selOh));
  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reqFire |=> rspValid);
  // R9
  err_excl_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rspAccErr && rspWrDone));
  // R9
  err_needs_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspAccErr |-> (rspWriteProt && rspValid));
  // R10
  done_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspWrDone |-> $past(strobe.reqWr));
endmodule

// File: rtl/acm_top.sv
module acm_top
  import acm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgWdata,
  output logic [WORD_W-1:0] cfgRdata,
  input  logic              reqValid,
  input  logic [WORD_W-1:0] reqAddr,
  input  logic              reqSuper,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic              rspCacheable,
  output logic              rspBuffered,
  output logic              rspWriteProt,
  output logic              rspAccErr,
  output logic              rspWrDone
);
  acmStrobe_t strobe;

  acm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .reqValid(reqValid), .reqWrite(reqWrite), .strobe(strobe)
  );

  acm_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .reqAddr(reqAddr),
    .reqSuper(reqSuper), .rspValid(rspValid), .rspCacheable(rspCacheable),
    .rspBuffered(rspBuffered), .rspWriteProt(rspWriteProt),
    .rspAccErr(rspAccErr), .rspWrDone(rspWrDone)
  );
endmodule

// File: tb/acm_top_tb_top.sv
module acm_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic reqSuper = 1'b0;
  logic reqWrite = 1'b0;
  logic rspValid, rspCacheable, rspBuffered, rspWriteProt, rspAccErr, rspWrDone;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [31:0] mReg [2];
  logic [31:0] mDef;

  always #2 clk = ~clk;

  acm_top dut_i (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] keepOf(input int sel);
    if (sel < 2) return 32'hFFFF_E064;
    if (sel == 2) return 32'h0000_0064;
    return 32'h0;
  endfunction

  // expected {valid, cacheable, buffered, wp, err, done}
  function automatic logic [5:0] expRsp(input logic v, input logic [31:0] a,
                                        input logic s, input logic w);
    logic [31:0] word;
    word = mDef;
    for (int i = 1; i >= 0; i--) begin
      logic [7:0] base, msk;
      logic [1:0] md;
      base = mReg[i][31:24]; msk = mReg[i][23:16]; md = mReg[i][14:13];
      if (mReg[i][15] && (((base ^ a[31:24]) & ~msk) == 8'd0) && (md[1] || md[0] == s))
        word = mReg[i];
    end
    if (!v) return 6'b0;
    return {1'b1, !word[6], word[5], word[2], w && word[2], w && !word[2]};
  endfunction

  task automatic cfgWrite(input int sel, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = 2'(sel); cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (sel < 2) mReg[sel] = d & keepOf(sel);
    else if (sel == 2) mDef = d & keepOf(sel);
  endtask

  task automatic cfgCheck(input int sel, input string req);
    logic [31:0] e;
    cfgAddr = 2'(sel);
    #1;
    e = (sel < 2) ? mReg[sel] : (sel == 2) ? mDef : 32'h0;
    check(cfgRdata, e, req);
  endtask

  task automatic doReq(input logic v, input logic [31:0] a, input logic s,
                       input logic w, input string req);
    logic [5:0] e;
    e = expRsp(v, a, s, w);
    reqValid = v; reqAddr = a; reqSuper = s; reqWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
    check({26'b0, rspValid, rspCacheable, rspBuffered, rspWriteProt, rspAccErr, rspWrDone},
          {26'b0, e}, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_ACE1));
    mReg[0] = '0; mReg[1] = '0; mDef = '0;
    repeat (3) @(negedge clk);
    // R1 reset state of outputs and registers
    check({26'b0, rspValid, rspCacheable, rspBuffered, rspWriteProt, rspAccErr, rspWrDone},
          32'h0, "R1 outputs in reset");
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) cfgCheck(i, "R1 register reset");
    doReq(1'b1, 32'hAB00_0000, 1'b0, 1'b1, "R7 default after reset");

    // R2 field masking and unused address
    for (int i = 0; i < 4; i++) begin
      cfgWrite(i, 32'hFFFF_FFFF);
      cfgCheck(i, "R2 readback mask");
    end
    cfgWrite(3, 32'h1234_5678);
    for (int i = 0; i < 4; i++) cfgCheck(i, "R2 addr3 write ignored");

    // R3 masked compare boundaries: base 0x5A, mask 0x0F, always mode, noncacheable
    cfgWrite(2, 32'h0);
    cfgWrite(1, 32'h0);
    cfgWrite(0, 32'h5A0F_C040);
    doReq(1'b1, 32'h5A12_3456, 1'b0, 1'b0, "R3 exact base");
    doReq(1'b1, 32'h5500_0000, 1'b1, 1'b0, "R3 masked bits differ");
    doReq(1'b1, 32'h4A00_0000, 1'b0, 1'b0, "R3 unmasked bit differs");
    doReq(1'b1, 32'hDA00_0000, 1'b0, 1'b0, "R3 msb differs");
    // R4 disabled region
    cfgWrite(0, 32'h5A0F_4040);
    doReq(1'b1, 32'h5A00_0000, 1'b0, 1'b0, "R4 disabled no match");
    // R5 mode codes
    for (int m = 0; m < 4; m++) begin
      cfgWrite(0, 32'h00FF_8024 | (32'(m) << 13));
      doReq(1'b1, 32'h1000_0000, 1'b0, 1'b0, "R5 user request");
      doReq(1'b1, 32'h1000_0000, 1'b1, 1'b0, "R5 supervisor request");
    end
    // R6 priority, conflicting attributes
    cfgWrite(0, 32'h30FF_C004);
    cfgWrite(1, 32'h30FF_C060);
    doReq(1'b1, 32'h3000_0000, 1'b0, 1'b0, "R6 region0 wins read");
    doReq(1'b1, 32'h3000_0000, 1'b1, 1'b1, "R6 region0 wins write");
    // R7 default register attributes
    cfgWrite(0, 32'h0); cfgWrite(1, 32'h0);
    cfgWrite(2, 32'h0000_0064);
    doReq(1'b1, 32'h7700_0000, 1'b0, 1'b0, "R7 default read");
    doReq(1'b1, 32'h7700_0000, 1'b0, 1'b1, "R7 default protected write");
    // R9 back-to-back protected read and write, R10 idle
    cfgWrite(2, 32'h0);
    cfgWrite(1, 32'h8800_C024);
    doReq(1'b1, 32'h8800_0000, 1'b1, 1'b1, "R9 protected write");
    doReq(1'b1, 32'h8800_0000, 1'b1, 1'b0, "R9 protected read");
    doReq(1'b1, 32'h8800_0000, 1'b0, 1'b1, "R9 protected write again");
    doReq(1'b0, 32'h8800_0000, 1'b0, 1'b1, "R10 idle write no strobes");
    doReq(1'b1, 32'h9900_0000, 1'b0, 1'b1, "R10 allowed write done");

    // random phase: R3 R5 R6 R7 R8 R9 R10
    for (int p = 0; p < 40; p++) begin
      for (int i = 0; i < 3; i++) cfgWrite(i, $urandom());
      for (int k = 0; k < 50; k++) begin
        logic [31:0] a;
        a = $urandom();
        if ($urandom_range(0, 2) != 0) begin
          int r;
          r = $urandom_range(0, 1);
          a[31:24] = mReg[r][31:24] ^ (8'($urandom()) & mReg[r][23:16]);
        end
        doReq(1'($urandom_range(0, 4) != 0), a, 1'($urandom()), 1'($urandom()),
              "R8 random attributes");
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule